// File: doc/BRIEF.md
# Dual-Current Fault Detect and Select

This block watches the averaged magnitudes of two current channels in a 2-wire metering path: channel A on the phase conductor and channel B on the neutral. Each time a new pair of magnitudes arrives with its valid strobe, it checks whether the two disagree by more than one sixteenth of the larger value. It then decides two things. The first is whether a fault flag should be raised or dropped. The second is which channel the downstream energy computation should bill from.

Both decisions are deliberately slow. A fault is raised only after the disagreement has been seen on a run of consecutive strobes, and it is dropped only after the same run of agreeing strobes. The billing selection moves to the other channel only when that channel has been the clearly larger one for the same run. Any strobe that breaks a run restarts that run's count. The selection keeps following the larger current while a fault is present, so billing stays correct with one conductor bypassed.

The run length `HOLD_UPD` is a parameter counted in valid strobes. At a fixed update rate it stands for the roughly three-second qualification time.

Top module: `curr_sel_guard`

## Requirements
- R1: On a valid strobe, the pair counts as mismatched only when |magA - magB| * 16 is strictly greater than max(magA, magB). A difference of exactly 1/16 of the larger value is not a mismatch.
- R2: While `fault` is 0, it becomes 1 after `HOLD_UPD` consecutive valid strobes that are all mismatched. The output changes on the second rising clock edge after the last of those strobes.
- R3: A valid strobe without a mismatch, arriving before the run of R2 completes, restarts the fault qualification from zero.
- R4: While `fault` is 1, it returns to 0 after `HOLD_UPD` consecutive valid strobes without a mismatch. A mismatched strobe restarts that count.
- R5: `selB` (0 = bill from channel A, 1 = bill from channel B) switches to the other channel after `HOLD_UPD` consecutive valid strobes on which the unselected channel is strictly larger and the pair is mismatched. It switches with the same latency as R2.
- R6: Selection follows the larger current whether `fault` is 0 or 1. The fault and swap qualifications run independently of each other.
- R7: When one channel reads zero and the other does not, the pair is mismatched. After `HOLD_UPD` strobes, the flag is raised and the non-zero channel is billed.
- R8: After reset, `selB` is 0 and `fault` is 0.
- R9: Magnitude inputs presented without `magValid` have no effect on `selB`, `fault` or any qualification count.
- R10: An unselected channel that is larger by no more than 1/16 of the larger value never takes over the selection, however long the condition lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| magValid | input | 1 | One-cycle strobe marking a new magnitude pair |
| magA | input | MAG_W | Averaged magnitude of channel A (phase) |
| magB | input | MAG_W | Averaged magnitude of channel B (neutral) |
| selB | output | 1 | Billing channel select, 1 = channel B |
| fault | output | 1 | Channel disagreement flag |

## Verification
The bench targets the threshold edge. At 1600 against 1500 the pair sits exactly on the 1/16 line, and a design using >= instead of > would raise the flag there. At 1600 against 1499 the pair is just past the line. Broken runs are driven one strobe short of the limit and then followed by a single agreeing strobe. A counter that does not clear would fire early, and one that clears on idle cycles would never fire. The bench also drives swaps while the flag is already raised, since a design that froze the selection during a fault would bill the wrong conductor. It finishes with a zero-current channel and with inputs wiggled without a strobe, which must leave both outputs untouched.

// File: rtl/faultsel_pkg.sv
package faultsel_pkg;

  // Flags produced by the comparison datapath for one magnitude pair.
  typedef struct packed {
    logic valid;     // flags below belong to a fresh strobe
    logic mismatch;  // difference exceeds 1/16 of the larger value
    logic aLarger;   // channel A strictly larger
    logic bLarger;   // channel B strictly larger
  } cmpFlags_t;

endpackage

// File: rtl/mag_compare.sv
module mag_compare
  import faultsel_pkg::*;
#(
  parameter int MAG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             magValid,
  input  logic [MAG_W-1:0] magA,
  input  logic [MAG_W-1:0] magB,
  output cmpFlags_t        cmpOut
);

  localparam int EXT_W = MAG_W + 4;

  logic             aBig;
  logic             bBig;
  logic [MAG_W-1:0] larger;
  logic [MAG_W-1:0] diff;
  logic [EXT_W-1:0] diffTimes16;
  logic [EXT_W-1:0] largerExt;
  logic             overLimit;

  always_comb begin
    aBig = magA > magB;
    bBig = magB > magA;
    if (aBig) begin
      larger = magA;
      diff   = magA - magB;
    end else begin
      larger = magB;
      diff   = magB - magA;
    end
    diffTimes16 = {diff, 4'b0000};
    largerExt   = {4'b0000, larger};
    overLimit   = diffTimes16 > largerExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpOut <= '0;
    end else begin
      cmpOut.valid <= magValid;
      if (magValid) begin
        cmpOut.mismatch <= overLimit;
        cmpOut.aLarger  <= aBig;
        cmpOut.bLarger  <= bBig;
      end
    end
  end

  AST_MISMATCH_UNEQUAL: assert property (@(posedge clk) disable iff (!rstN)
    cmpOut.valid && cmpOut.mismatch |-> (cmpOut.aLarger || cmpOut.bLarger)) // R1
    else $error("mismatch flagged on equal magnitudes");

  AST_NOT_BOTH_LARGER: assert property (@(posedge clk) disable iff (!rstN)
    !(cmpOut.aLarger && cmpOut.bLarger)) // R1
    else $error("both channels flagged larger");

endmodule

// File: rtl/hold_qualifier.sv
module hold_qualifier #(
  parameter int HOLD_UPD = 3000
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic cond,
  output logic fire
);

  localparam int CW = (HOLD_UPD > 1) ? $clog2(HOLD_UPD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_UPD - 1);

  logic [CW-1:0] runCnt;

  assign fire = tick && cond && (runCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (tick) begin
      if (!cond || fire) runCnt <= '0;
      else               runCnt <= runCnt + 1'b1;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= LAST) // R3
    else $error("qualification count beyond limit");

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    tick && !cond |=> runCnt == '0) // R3
    else $error("run not restarted on broken condition");

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(runCnt)) // R9
    else $error("count moved without strobe");

endmodule

// File: rtl/sel_ctrl.sv
module sel_ctrl
  import faultsel_pkg::*;
#(
  parameter int HOLD_UPD = 3000
) (
  input  logic      clk,
  input  logic      rstN,
  input  cmpFlags_t cmpIn,
  output logic      selB,
  output logic      fault
);

  logic faultCond;
  logic swapCond;
  logic faultFire;
  logic swapFire;

  always_comb begin
    faultCond = fault ? !cmpIn.mismatch : cmpIn.mismatch;
    swapCond  = cmpIn.mismatch && (selB ? cmpIn.aLarger : cmpIn.bLarger);
  end

  hold_qualifier #(.HOLD_UPD(HOLD_UPD)) i_faultQual (
    .clk  (clk),
    .rstN (rstN),
    .tick (cmpIn.valid),
    .cond (faultCond),
    .fire (faultFire)
  );

  hold_qualifier #(.HOLD_UPD(HOLD_UPD)) i_swapQual (
    .clk  (clk),
    .rstN (rstN),
    .tick (cmpIn.valid),
    .cond (swapCond),
    .fire (swapFire)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selB  <= 1'b0;
      fault <= 1'b0;
    end else begin
      if (faultFire) fault <= !fault;
      if (swapFire)  selB  <= !selB;
    end
  end

  AST_FAULT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fault) |-> $past(cmpIn.valid && cmpIn.mismatch)) // R2
    else $error("fault rose without mismatch");

  AST_FAULT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fault) |-> $past(cmpIn.valid && !cmpIn.mismatch)) // R4
    else $error("fault fell during mismatch");

  AST_SWAP_TO_B: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selB) |-> $past(cmpIn.valid && cmpIn.mismatch && cmpIn.bLarger)) // R5
    else $error("switched to B without B clearly larger");

  AST_SWAP_TO_A: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selB) |-> $past(cmpIn.valid && cmpIn.mismatch && cmpIn.aLarger)) // R6
    else $error("switched to A without A clearly larger");

  AST_NO_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cmpIn.valid) |-> ($stable(selB) && $stable(fault))) // R9
    else $error("outputs moved without strobe");

endmodule

// File: rtl/curr_sel_guard.sv
module curr_sel_guard
  import faultsel_pkg::*;
#(
  parameter int MAG_W    = 16,
  parameter int HOLD_UPD = 3000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             magValid,
  input  logic [MAG_W-1:0] magA,
  input  logic [MAG_W-1:0] magB,
  output logic             selB,
  output logic             fault
);

  cmpFlags_t cmpFlags;

  mag_compare #(.MAG_W(MAG_W)) i_cmp (
    .clk      (clk),
    .rstN     (rstN),
    .magValid (magValid),
    .magA     (magA),
    .magB     (magB),
    .cmpOut   (cmpFlags)
  );

  sel_ctrl #(.HOLD_UPD(HOLD_UPD)) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .cmpIn (cmpFlags),
    .selB  (selB),
    .fault (fault)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (!selB && !fault)) // R8
    else $error("outputs not cleared by reset");

endmodule

// File: tb/test_curr_sel_guard.sv
`timescale 1ns/1ps
module test_curr_sel_guard;

  localparam int MAG_W = 16;
  localparam int HOLD  = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             magValid = 1'b0;
  logic [MAG_W-1:0] magA = '0;
  logic [MAG_W-1:0] magB = '0;
  logic             selB;
  logic             fault;

  always #5 clk = ~clk;

  curr_sel_guard #(.MAG_W(MAG_W), .HOLD_UPD(HOLD)) i_curr_sel_guard (
    .clk      (clk),
    .rstN     (rstN),
    .magValid (magValid),
    .magA     (magA),
    .magB     (magB),
    .selB     (selB),
    .fault    (fault)
  );

  typedef struct {
    logic  expSel;
    logic  expFault;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int testCnt = 0;
  int failCnt = 0;

  // Independent reference state built from the requirements.
  logic mSel = 1'b0;
  logic mFault = 1'b0;
  int   mFaultRun = 0;
  int   mSwapRun = 0;

  function automatic bit isMismatch(int a, int b);
    int big;
    int d;
    big = (a > b) ? a : b;
    d   = (a > b) ? a - b : b - a;
    return (d * 16) > big;
  endfunction

  task automatic modelStep(int a, int b);
    bit mis;
    bit fCond;
    bit sCond;
    mis   = isMismatch(a, b);
    fCond = mFault ? !mis : mis;
    sCond = mis && (mSel ? (a > b) : (b > a));
    if (fCond) begin
      mFaultRun++;
      if (mFaultRun == HOLD) begin
        mFault = !mFault;
        mFaultRun = 0;
      end
    end else mFaultRun = 0;
    if (sCond) begin
      mSwapRun++;
      if (mSwapRun == HOLD) begin
        mSel = !mSel;
        mSwapRun = 0;
      end
    end else mSwapRun = 0;
  endtask

  task automatic drive(int a, int b, bit v, string tag);
    expItem_t it;
    magA     = MAG_W'(a);
    magB     = MAG_W'(b);
    magValid = v;
    @(negedge clk);
    magValid = 1'b0;
    if (v) modelStep(a, b);
    it.expSel   = mSel;
    it.expFault = mFault;
    it.tag      = tag;
    expQ.push_back(it);
    repeat (4) @(negedge clk);
  endtask

  task automatic driveN(int a, int b, int n, string tag);
    for (int i = 0; i < n; i++) drive(a, b, 1'b1, tag);
  endtask

  // Monitor: compare each expected item once the result has settled.
  initial begin
    expItem_t got;
    forever begin
      wait (expQ.size() > 0);
      repeat (3) @(negedge clk);
      got = expQ.pop_front();
      testCnt++;
      if (selB !== got.expSel || fault !== got.expFault) begin
        failCnt++;
        $display("FAIL %s: selB=%0b fault=%0b expected selB=%0b fault=%0b",
                 got.tag, selB, fault, got.expSel, got.expFault);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state observed while reset is held and just after release
    testCnt++;
    if (selB !== 1'b0 || fault !== 1'b0) begin
      failCnt++;
      $display("FAIL R8: selB=%0b fault=%0b expected selB=0 fault=0", selB, fault);
    end
    rstN = 1'b1;
    @(negedge clk);
    drive(0, 0, 1'b0, "R8");

    // R1: equal and exactly-on-threshold pairs are not mismatches
    driveN(1000, 1000, 2, "R1_equal");
    driveN(1600, 1500, 5, "R1_boundary");
    // R10: B slightly larger for a long time never takes over
    driveN(1500, 1600, 6, "R10");
    driveN(1000, 1050, 6, "R10");

    // R3: run one short, broken by an agreeing strobe, then restart
    driveN(1600, 1499, 3, "R3");
    drive(1600, 1600, 1'b1, "R3");
    driveN(1600, 1499, 3, "R3");
    // R2: fourth consecutive mismatch raises the flag
    drive(1600, 1499, 1'b1, "R2");

    // R4: agreement clears the flag, with an interrupted run first
    driveN(1000, 1000, 3, "R4");
    drive(1000, 500, 1'b1, "R4");
    driveN(1000, 1010, 4, "R4");

    // R5: B clearly larger swaps the selection (flag rises together)
    driveN(1000, 2000, 4, "R5");
    driveN(1000, 2000, 2, "R5_hold");
    // R6: A clearly larger while the flag is up: selection returns to A
    driveN(3000, 1000, 4, "R6");
    driveN(2000, 2000, 4, "R6_clear");

    // R9: inputs moving without a strobe change nothing
    drive(0, 5000, 1'b0, "R9");
    drive(9000, 1, 1'b0, "R9");
    drive(0, 5000, 1'b0, "R9");
    driveN(0, 5000, 3, "R9_count");
    drive(2000, 2000, 1'b0, "R9");
    drive(0, 5000, 1'b1, "R9_count");

    // R7: channel A dead, B carrying load
    driveN(2000, 2000, 4, "R7_prep");
    driveN(0, 800, 4, "R7");
    driveN(0, 800, 2, "R7_hold");

    wait (expQ.size() == 0);
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule